// File: doc/BRIEF.md
# PWM Counter Compare Event Generator

This block watches the counter of the reference channel of a multi-channel PWM and compares it against a bank of programmable values, one per compare unit. When an enabled unit sees its value on the counter, it sets a sticky interrupt flag. It can also fire a one-clock strobe on one or more event lines, which are used to time ADC conversions apart from the PWM outputs. It can also request a DMA transfer. Waveform generation stays in the PWM channels. This block only consumes the counter value, a strobe that marks each new counter value, and a wrap marker.

Software programs the block through a simple write port. Compare values are double-buffered. A write lands in a shadow register, and the unit adopts it when the reference counter wraps, so a compare point never moves in the middle of a period. A separate read strobe on the status register clears the interrupt flags.

Top module: `pwm_cmp_events`

## Requirements
- R1: While reset is applied and in the first cycle after it, `irq_flags`, `irq`, `evt_pulse` and `dma_req` are all zero.
- R2: Unit i matches in a cycle when its enable bit is set, `cnt_vld` is high and `cnt_val` equals its active compare value. All outputs reflect a match one clock later.
- R3: A flag bit stays set until it is cleared by a status read or by disabling its unit. `irq` is high whenever any flag bit is set.
- R4: A `stat_rd` strobe clears every flag bit on the next clock. If a unit matches in the same cycle as the strobe, its bit is set instead.
- R5: Event line l pulses high for one clock after each cycle in which a unit selected by its mask matches. The mask for line l is written at address NUM_UNITS+1+l, and bit i selects unit i.
- R6: `dma_req` pulses high for one clock after each cycle in which a unit selected by the DMA mask matches. The DMA mask is written at address NUM_UNITS+1+NUM_LINES, and bit i selects unit i.
- R7: A write to address i (i < NUM_UNITS) loads only the shadow compare value of unit i. The active value takes the shadow value when `cnt_vld` and `cnt_wrap` are both high. The comparison in that wrap cycle already uses the shadow value.
- R8: The enable register is written at address NUM_UNITS, and bit i enables unit i. A disabled unit sets no flag, causes no event pulse and causes no DMA request. One clock after its enable bit reads zero, its flag is zero.
- R9: A cycle with `cnt_vld` low produces no match, even when `cnt_val` equals a compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Reference channel counter value |
| cnt_vld | input | 1 | `cnt_val` carries a new counter value this cycle |
| cnt_wrap | input | 1 | The presented value is the first one of a new period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| irq_flags | output | NUM_UNITS | Sticky per-unit match flags |
| irq | output | 1 | OR of all flags |
| evt_pulse | output | NUM_LINES | One-clock event strobes |
| dma_req | output | 1 | One-clock DMA request strobe |

## Verification
The bench keeps the default of eight units and two event lines. This gives full-width masks and the real routing of eight units onto two lines. It narrows CNT_W and DATA_W to 8, so a complete counter period takes only 256 steps. Whole sweeps from wrap to wrap therefore fit many times into the run. They cover the shadow-to-active hand-over at the wrap, units sharing one compare value, the values at both ends of the counter range, and disabling units partway through.

// File: rtl/pwm_cmp_events.sv
module pwm_cmp_events #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_LINES = 2,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt_val,
  input  logic                 cnt_vld,
  input  logic                 cnt_wrap,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 stat_rd,
  output logic [NUM_UNITS-1:0] irq_flags,
  output logic                 irq,
  output logic [NUM_LINES-1:0] evt_pulse,
  output logic                 dma_req
);
  localparam int A_EN   = NUM_UNITS;
  localparam int A_LINE = NUM_UNITS + 1;
  localparam int A_DMA  = NUM_UNITS + 1 + NUM_LINES;

  logic                 load;
  logic [NUM_UNITS-1:0] hit, en_q, dma_mask_q;
  logic [NUM_LINES-1:0] line_hit;

  assign load = cnt_vld & cnt_wrap;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [CNT_W-1:0] shadow_q, active_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(u)) shadow_q <= wr_data[CNT_W-1:0];
        if (load) active_q <= shadow_q;
      end
    end
    assign hit[u] = en_q[u] & cnt_vld & (cnt_val == (load ? shadow_q : active_q));
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_UNITS-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_LINE + l)) mask_q <= wr_data[NUM_UNITS-1:0];
    end
    assign line_hit[l] = |(hit & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      dma_mask_q <= '0;
      irq_flags  <= '0;
      evt_pulse  <= '0;
      dma_req    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_EN))  en_q       <= wr_data[NUM_UNITS-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_DMA)) dma_mask_q <= wr_data[NUM_UNITS-1:0];
      irq_flags <= ((irq_flags & ~{NUM_UNITS{stat_rd}}) | hit) & en_q;
      evt_pulse <= line_hit;
      dma_req   <= |(hit & dma_mask_q);
    end
  end

  assign irq = |irq_flags;
endmodule

module pwm_cmp_events_chk #(
  parameter int NUM_UNITS = 8,
  parameter int NUM_LINES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnt_vld,
  input logic                 stat_rd,
  input logic [NUM_UNITS-1:0] en_q,
  input logic [NUM_UNITS-1:0] dma_mask_q,
  input logic [NUM_UNITS-1:0] irq_flags,
  input logic [NUM_LINES-1:0] evt_pulse,
  input logic                 dma_req
);
  p_flag_rise_needs_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_flags & ~$past(irq_flags)) != '0) |-> $past(cnt_vld));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && ((irq_flags & en_q) != '0)) |=> ((irq_flags & $past(irq_flags & en_q)) == $past(irq_flags & en_q)));

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cnt_vld) |=> (irq_flags == '0));

  p_evt_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |-> $past(cnt_vld));

  p_dma_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ($past(cnt_vld) && $past(dma_mask_q) != '0));

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & ~$past(en_q)) == '0));

  p_no_vld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_vld |=> (evt_pulse == '0 && !dma_req));
endmodule

bind pwm_cmp_events pwm_cmp_events_chk #(.NUM_UNITS(NUM_UNITS), .NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_vld(cnt_vld), .stat_rd(stat_rd), .en_q(en_q),
  .dma_mask_q(dma_mask_q), .irq_flags(irq_flags), .evt_pulse(evt_pulse), .dma_req(dma_req)
);

// File: tb/pwm_cmp_events_tb_top.sv
`timescale 1ns/1ps
module pwm_cmp_events_tb_top;
  localparam int NU = 8, NL = 2, CW = 8, DW = 8, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic cnt_vld = 1'b0, cnt_wrap = 1'b0, wr_en = 1'b0, stat_rd = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NU-1:0] irq_flags;
  logic irq, dma_req;
  logic [NL-1:0] evt_pulse;

  always #2.5 clk = ~clk;

  pwm_cmp_events #(.NUM_UNITS(NU), .NUM_LINES(NL), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_vld(cnt_vld), .cnt_wrap(cnt_wrap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
    .irq_flags(irq_flags), .irq(irq), .evt_pulse(evt_pulse), .dma_req(dma_req));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  int            q_tgt[$];
  logic [NU-1:0] q_flags[$];
  logic [NL-1:0] q_evt[$];
  logic          q_dma[$];
  string         q_tag[$];

  logic [CW-1:0] m_shadow[NU], m_active[NU];
  logic [NU-1:0] m_en = '0, m_dma = '0, m_flags = '0;
  logic [NU-1:0] m_mask[NL];

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic vld, logic [CW-1:0] val, logic wrap, logic wr,
                      logic [AW-1:0] addr, logic [DW-1:0] data, logic rd, string tag);
    logic [NU-1:0] hit;
    logic [NL-1:0] ev;
    logic ld;
    @(negedge clk);
    cnt_vld = vld; cnt_val = val; cnt_wrap = wrap;
    wr_en = wr; wr_addr = addr; wr_data = data; stat_rd = rd;
    ld = vld & wrap;
    for (int i = 0; i < NU; i++)
      hit[i] = m_en[i] & vld & (val == (ld ? m_shadow[i] : m_active[i]));
    for (int l = 0; l < NL; l++) ev[l] = |(hit & m_mask[l]);
    m_flags = ((m_flags & ~{NU{rd}}) | hit) & m_en;
    q_tgt.push_back(cyc + 1); q_flags.push_back(m_flags); q_evt.push_back(ev);
    q_dma.push_back(|(hit & m_dma)); q_tag.push_back(tag);
    for (int i = 0; i < NU; i++) if (ld) m_active[i] = m_shadow[i];
    if (wr) begin
      if (int'(addr) < NU) m_shadow[addr] = data;
      else if (int'(addr) == NU) m_en = data;
      else if (int'(addr) <= NU + NL) m_mask[int'(addr) - NU - 1] = data;
      else if (int'(addr) == NU + NL + 1) m_dma = data;
    end
  endtask

  task automatic wreg(int a, int d, string tag);
    step(1'b0, '0, 1'b0, 1'b1, AW'(a), DW'(d), 1'b0, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < 256; v++) step(1'b1, CW'(v), v == 0, 1'b0, '0, '0, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (q_tgt.size() > 0 && q_tgt[0] == cyc) begin
      string t;
      t = q_tag.pop_front();
      check(t, "irq_flags", int'(irq_flags), int'(q_flags[0]));
      check(t, "irq", int'(irq), int'(|q_flags[0]));
      check(t, "evt_pulse", int'(evt_pulse), int'(q_evt.pop_front()));
      check(t, "dma_req", int'(dma_req), int'(q_dma.pop_front()));
      void'(q_flags.pop_front());
      void'(q_tgt.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NU; i++) begin m_shadow[i] = '0; m_active[i] = '0; end
    for (int l = 0; l < NL; l++) m_mask[l] = '0;
    repeat (3) @(negedge clk);
    check("R1", "irq_flags in reset", int'(irq_flags), 0);
    check("R1", "evt_pulse in reset", int'(evt_pulse), 0);
    check("R1", "dma_req in reset", int'(dma_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "irq after reset", int'(irq), 0);
    for (int i = 0; i < NU; i++) wreg(i, 16 * i + 5, "R7 shadow write");
    wreg(NU, 8'hFF, "R8 enable");
    wreg(NU + 1, 8'h0F, "R5 mask0");
    wreg(NU + 2, 8'hF0, "R5 mask1");
    wreg(NU + 3, 8'h81, "R6 dma mask");
    step(1'b1, 8'd5, 1'b0, 1'b0, '0, '0, 1'b0, "R7 no early take-over");
    step(1'b1, 8'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R2 match on active zero");
    idle("R3 sticky");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, "R4 read clears");
    sweep("R7 R2 R5 R6 sweep");
    step(1'b1, 8'd5, 1'b0, 1'b0, '0, '0, 1'b1, "R4 read with match");
    step(1'b0, 8'd21, 1'b0, 1'b0, '0, '0, 1'b0, "R9 vld low");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, "R4 clear");
    sweep("R3 flags accumulate");
    wreg(NU, 8'hF1, "R8 disable 1..3");
    idle("R8 flag drop");
    sweep("R8 disabled sweep");
    wreg(2, 100, "R7 shared value");
    wreg(6, 100, "R7 shared value");
    wreg(7, 255, "R7 top value");
    wreg(NU, 8'hFF, "R8 re-enable");
    step(1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b1, "R4 clear");
    sweep("R5 shared take-over");
    sweep("R5 R6 shared lines");
    repeat (4) idle("R3 drain");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule